// File: doc/BRIEF.md
# Learned Prefetch Engine Selector

This block decides which of three prefetch engines sits in front of a DRAM cache for a slower non-volatile main memory. It watches two quantities of the memory system. The first is last-level-cache misses per thousand retired instructions. The second is the hit fraction of the DRAM cache over a fixed window of requests. Each quantity is reduced to one of four bins, and the two bins together form one of sixteen states. For every pair of state and engine, the block holds a learned value in a 48-entry table.

Each accepted last-level-cache miss runs two steps. First, the value of the previous state/engine pair is updated with a fixed-point temporal-difference rule. The reward in that rule is the latest DRAM-cache hit fraction. Second, a new engine is chosen for the current state. The choice is normally the best entry of the state's row. With a programmable probability, set by comparing an external pseudo-random byte against a threshold, a random engine is chosen instead. A debug port reads back any table entry.

Engine codes are 0 for the streaming engine, 1 for the delta/distance engine and 2 for the access-map pattern engine.

Top module: `rl_pf_select`

## Requirements
- R1: After reset the selected engine is code 0 (one-hot 3'b001), and every one of the 48 table entries reads 0.
- R2: The DRAM-cache hit fraction becomes min(255, hits*256/WINDOW) once WINDOW valid requests have been counted. At that point both the request counter and the hit counter restart from zero. Cycles without a valid request leave the fraction unchanged.
- R3: The miss-rate figure becomes the number of miss strobes seen since the last latch, saturated at 255, once the retired-instruction count reaches KILO. Any instructions past KILO carry over to the next period.
- R4: Each attribute's bin is the number of its three threshold bytes (packed low byte first) that the value is greater than or equal to. The state index is miss_bin*4 + hit_bin. Table entry index is state*3 + engine code.
- R5: On each accepted miss, except the first one after reset, the entry of the previous (state, engine) pair is rewritten with sat16(((old*26)>>8) + (((r + ((maxQ*205)>>8))*230)>>8)). Here r is the hit fraction at the miss and maxQ is the largest entry of the current state's row. No other entry changes.
- R6: In greedy mode the chosen engine is the one with the largest entry in the current state's row, read after that miss's update. On a tie, the lowest code wins.
- R7: If the random byte sampled with the miss is strictly below the epsilon byte, the engine is taken from the random byte's two low bits, with the value 3 mapped to 0. Otherwise the greedy choice of R6 applies.
- R8: The miss is sampled at clock edge k. The table is written at edge k+1, and the engine output changes only at edge k+2. Miss strobes at edges k+1 and k+2 are ignored by the learner, although R3 still counts them.
- R9: The one-hot output always equals 1 shifted left by the engine code. A debug index of 48 or more reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| llc_miss_i | input | 1 | One-cycle last-level-cache miss strobe |
| dc_valid_i | input | 1 | DRAM-cache request completed this cycle |
| dc_hit_i | input | 1 | That request hit (qualified by dc_valid_i) |
| instr_inc_i | input | IRW | Instructions retired this cycle |
| rand_i | input | 8 | Pseudo-random byte |
| eps_i | input | 8 | Exploration threshold |
| mpki_thr_i | input | 24 | Three miss-rate bin thresholds, ascending, low byte first |
| hit_thr_i | input | 24 | Three hit-fraction bin thresholds, ascending, low byte first |
| dbg_idx_i | input | 6 | Table entry to read back |
| dbg_q_o | output | 16 | Value of the addressed entry (Q8.8) |
| pf_code_o | output | 2 | Selected engine code |
| pf_onehot_o | output | 3 | Selected engine, one-hot |

## Verification
The bench builds the block with WINDOW=16 and KILO=16 instead of 10,000 and 1,000. This lets a 16-request burst set the hit fraction exactly to 128 or 255, and a single retire pulse latch the miss count, so state changes and saturation of the fraction come within a few dozen cycles. With these sizes, a reference model of the value update and the engine choice can be stepped miss by miss. This covers the first-miss case with no update, random picks including the remapped code 3, the epsilon boundary, ties in fresh rows, and a miss strobe that arrives while an update is still in flight.

// File: rtl/rlps_pkg.sv
package rlps_pkg;

    localparam int NACT  = 3;
    localparam int QW    = 16;
    localparam int RW    = 8;
    localparam int NTHR  = 3;
    localparam int BINW  = 2;
    localparam int STW   = 2 * BINW;
    localparam int NSTATE = 1 << STW;
    localparam int NENT  = NSTATE * NACT;
    localparam int IDXW  = $clog2(NENT);

    localparam logic [7:0] K_LEARN = 8'd230;
    localparam logic [7:0] K_KEEP  = 8'd26;
    localparam logic [7:0] K_DISC  = 8'd205;

    typedef logic [QW-1:0] qval_t;

    typedef enum logic [1:0] {
        ENG_STREAM = 2'd0,
        ENG_DELTA  = 2'd1,
        ENG_MAP    = 2'd2
    } eng_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_UPD  = 2'd1,
        PH_SEL  = 2'd2
    } phase_e;

    typedef struct packed {
        logic [BINW-1:0] miss_bin;
        logic [BINW-1:0] hit_bin;
    } state_t;

    function automatic logic [BINW-1:0] bin_of(input logic [RW-1:0] v,
                                               input logic [NTHR*RW-1:0] thr);
        logic [BINW-1:0] n;
        n = '0;
        for (int i = 0; i < NTHR; i++) begin
            if (v >= thr[i*RW +: RW]) n = n + 1'b1;
        end
        return n;
    endfunction

    function automatic logic [IDXW-1:0] entry_idx(input state_t s, input eng_e a);
        int unsigned v;
        v = int'(s) * NACT + int'(a);
        return IDXW'(v);
    endfunction

    function automatic qval_t q_blend(input qval_t old, input logic [RW-1:0] r,
                                      input qval_t best);
        logic [QW+7:0] p_keep;
        logic [QW+7:0] p_disc;
        logic [QW:0]   target;
        logic [QW+8:0] p_learn;
        logic [QW+1:0] total;
        p_keep  = {8'd0, old} * {{QW{1'b0}}, K_KEEP};
        p_disc  = {8'd0, best} * {{QW{1'b0}}, K_DISC};
        target  = {1'b0, p_disc[QW+7:8]} + {{(QW+1-RW){1'b0}}, r};
        p_learn = {8'd0, target} * {{(QW+1){1'b0}}, K_LEARN};
        total   = {2'b00, p_keep[QW+7:8]} + {1'b0, p_learn[QW+8:8]};
        if (total > {2'b00, {QW{1'b1}}}) return {QW{1'b1}};
        return total[QW-1:0];
    endfunction

endpackage

// File: rtl/rlps_stats.sv
module rlps_stats #(
    parameter int WINDOW = 10000,
    parameter int KILO   = 1000,
    parameter int IRW    = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           dc_valid,
    input  logic           dc_hit,
    input  logic           llc_miss,
    input  logic [IRW-1:0] instr_inc,
    output logic [7:0]     hit_rate,
    output logic [7:0]     mpki
);
    localparam int CW = $clog2(WINDOW + 1);
    localparam int SW = CW + 8;
    localparam int KW = $clog2(KILO + (1 << IRW) + 1);

    logic [CW-1:0] req_cnt, hit_cnt, req_nx, hit_nx;
    logic [SW-1:0] scaled;
    logic [7:0]    rate_nx;

    assign req_nx  = req_cnt + 1'b1;
    assign hit_nx  = hit_cnt + {{(CW-1){1'b0}}, dc_hit};
    assign scaled  = {hit_nx, 8'h00} / SW'(WINDOW);
    assign rate_nx = (scaled > SW'(255)) ? 8'hFF : scaled[7:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            req_cnt  <= '0;
            hit_cnt  <= '0;
            hit_rate <= '0;
        end else if (dc_valid) begin
            if (req_nx == CW'(WINDOW)) begin
                hit_rate <= rate_nx;
                req_cnt  <= '0;
                hit_cnt  <= '0;
            end else begin
                req_cnt <= req_nx;
                hit_cnt <= hit_nx;
            end
        end
    end

    logic [KW-1:0] acc, acc_sum;
    logic [7:0]    miss_cnt, miss_nx;

    assign acc_sum = acc + KW'(instr_inc);
    assign miss_nx = (llc_miss && miss_cnt != 8'hFF) ? miss_cnt + 8'd1 : miss_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc      <= '0;
            miss_cnt <= '0;
            mpki     <= '0;
        end else if (acc_sum >= KW'(KILO)) begin
            mpki     <= miss_nx;
            miss_cnt <= '0;
            acc      <= acc_sum - KW'(KILO);
        end else begin
            acc      <= acc_sum;
            miss_cnt <= miss_nx;
        end
    end
endmodule

// File: rtl/rlps_binner.sv
module rlps_binner
    import rlps_pkg::*;
(
    input  logic [RW-1:0]      value,
    input  logic [NTHR*RW-1:0] thr,
    output logic [BINW-1:0]    bin
);
    assign bin = bin_of(value, thr);
endmodule

// File: rtl/rlps_qtable.sv
module rlps_qtable
    import rlps_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      we,
    input  logic [IDXW-1:0]           widx,
    input  qval_t                     wdata,
    input  state_t                    row_st,
    output logic [NACT-1:0][QW-1:0]   row,
    input  logic [IDXW-1:0]           ridx,
    output qval_t                     rval,
    input  logic [IDXW-1:0]           dbg_idx,
    output qval_t                     dbg_val,
    output logic [NENT-1:0][QW-1:0]   q_all
);
    logic [NENT-1:0][QW-1:0] mem;

    always_ff @(posedge clk) begin
        if (rst) begin
            mem <= '0;
        end else if (we) begin
            mem[widx] <= wdata;
        end
    end

    for (genvar a = 0; a < NACT; a++) begin : g_row
        assign row[a] = mem[entry_idx(row_st, eng_e'(a))];
    end

    assign rval    = mem[ridx];
    assign dbg_val = (int'(dbg_idx) < NENT) ? mem[dbg_idx] : '0;
    assign q_all   = mem;
endmodule

// File: rtl/rlps_pick.sv
module rlps_pick
    import rlps_pkg::*;
(
    input  logic [NACT-1:0][QW-1:0] row,
    input  logic [7:0]              rnd,
    input  logic [7:0]              eps,
    output eng_e                    choice,
    output qval_t                   best
);
    eng_e  greedy;
    eng_e  wild;

    always_comb begin
        greedy = ENG_STREAM;
        best   = row[0];
        for (int a = 1; a < NACT; a++) begin
            if (row[a] > best) begin
                best   = row[a];
                greedy = eng_e'(a);
            end
        end
    end

    assign wild   = (rnd[1:0] == 2'd3) ? ENG_STREAM : eng_e'(rnd[1:0]);
    assign choice = (rnd < eps) ? wild : greedy;
endmodule

// File: rtl/rl_pf_select.sv
module rl_pf_select
    import rlps_pkg::*;
#(
    parameter int WINDOW = 10000,
    parameter int KILO   = 1000,
    parameter int IRW    = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           llc_miss_i,
    input  logic           dc_valid_i,
    input  logic           dc_hit_i,
    input  logic [IRW-1:0] instr_inc_i,
    input  logic [7:0]     rand_i,
    input  logic [7:0]     eps_i,
    input  logic [23:0]    mpki_thr_i,
    input  logic [23:0]    hit_thr_i,
    input  logic [5:0]     dbg_idx_i,
    output logic [15:0]    dbg_q_o,
    output logic [1:0]     pf_code_o,
    output logic [2:0]     pf_onehot_o
);
    logic [7:0] hit_rate, mpki;

    rlps_stats #(.WINDOW(WINDOW), .KILO(KILO), .IRW(IRW)) u_stats (
        .clk(clk), .rst(rst),
        .dc_valid(dc_valid_i), .dc_hit(dc_hit_i),
        .llc_miss(llc_miss_i), .instr_inc(instr_inc_i),
        .hit_rate(hit_rate), .mpki(mpki)
    );

    logic [1:0][RW-1:0]      attr_val;
    logic [1:0][NTHR*RW-1:0] attr_thr;
    logic [1:0][BINW-1:0]    attr_bin;
    state_t                  st_now;

    assign attr_val[0] = hit_rate;
    assign attr_val[1] = mpki;
    assign attr_thr[0] = hit_thr_i;
    assign attr_thr[1] = mpki_thr_i;

    for (genvar g = 0; g < 2; g++) begin : g_bin
        rlps_binner u_bin (.value(attr_val[g]), .thr(attr_thr[g]), .bin(attr_bin[g]));
    end

    assign st_now.hit_bin  = attr_bin[0];
    assign st_now.miss_bin = attr_bin[1];

    phase_e     phase_q;
    state_t     s_cur_q, s_prev_q;
    eng_e       a_prev_q, sel_q;
    logic       prev_vld_q;
    logic [7:0] rnd_q, eps_q, rew_q;

    logic [NACT-1:0][QW-1:0] row;
    logic [NENT-1:0][QW-1:0] tbl_all;
    qval_t                   old_val, new_val, best;
    eng_e                    choice;
    logic                    tbl_we;
    logic [IDXW-1:0]         widx;

    assign widx    = entry_idx(s_prev_q, a_prev_q);
    assign tbl_we  = (phase_q == PH_UPD) && prev_vld_q;
    assign new_val = q_blend(old_val, rew_q, best);

    rlps_qtable u_tbl (
        .clk(clk), .rst(rst),
        .we(tbl_we), .widx(widx), .wdata(new_val),
        .row_st(s_cur_q), .row(row),
        .ridx(widx), .rval(old_val),
        .dbg_idx(dbg_idx_i), .dbg_val(dbg_q_o),
        .q_all(tbl_all)
    );

    rlps_pick u_pick (
        .row(row), .rnd(rnd_q), .eps(eps_q),
        .choice(choice), .best(best)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q    <= PH_IDLE;
            s_cur_q    <= '0;
            s_prev_q   <= '0;
            a_prev_q   <= ENG_STREAM;
            sel_q      <= ENG_STREAM;
            prev_vld_q <= 1'b0;
            rnd_q      <= '0;
            eps_q      <= '0;
            rew_q      <= '0;
        end else begin
            unique case (phase_q)
                PH_IDLE: begin
                    if (llc_miss_i) begin
                        s_cur_q <= st_now;
                        rnd_q   <= rand_i;
                        eps_q   <= eps_i;
                        rew_q   <= hit_rate;
                        phase_q <= PH_UPD;
                    end
                end
                PH_UPD: begin
                    phase_q <= PH_SEL;
                end
                PH_SEL: begin
                    sel_q      <= choice;
                    a_prev_q   <= choice;
                    s_prev_q   <= s_cur_q;
                    prev_vld_q <= 1'b1;
                    phase_q    <= PH_IDLE;
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign pf_code_o = sel_q;

    for (genvar a = 0; a < NACT; a++) begin : g_hot
        assign pf_onehot_o[a] = (sel_q == eng_e'(a));
    end
endmodule

// File: rtl/rl_pf_select_chk.sv
module rl_pf_select_chk
    import rlps_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    llc_miss_i,
    input  logic                    dc_valid_i,
    input  logic [1:0]              phase,
    input  logic [1:0]              pf_code_o,
    input  logic [2:0]              pf_onehot_o,
    input  logic [7:0]              hit_rate,
    input  logic [NENT-1:0][QW-1:0] tbl_all
);
    assert_sel_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_SEL) |=> $stable(pf_code_o));

    assert_upd_to_sel_R8: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_UPD) |=> (phase == PH_SEL));

    assert_sel_to_idle_R8: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_SEL) |=> (phase == PH_IDLE));

    assert_idle_wait_R8: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE && !llc_miss_i) |=> (phase == PH_IDLE));

    assert_table_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_UPD) |=> $stable(tbl_all));

    assert_rate_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !dc_valid_i |=> $stable(hit_rate));

    assert_onehot_match_R9: assert property (@(posedge clk) disable iff (rst)
        pf_onehot_o == (3'b001 << pf_code_o));

    assert_code_legal_R7: assert property (@(posedge clk) disable iff (rst)
        pf_code_o != 2'd3);
endmodule

bind rl_pf_select rl_pf_select_chk u_chk (
    .clk(clk), .rst(rst), .llc_miss_i(llc_miss_i), .dc_valid_i(dc_valid_i),
    .phase(phase_q), .pf_code_o(pf_code_o), .pf_onehot_o(pf_onehot_o),
    .hit_rate(hit_rate), .tbl_all(tbl_all)
);

// File: tb/rl_pf_select_tb.sv
module rl_pf_select_tb;
    localparam int WIN = 16;
    localparam int KIL = 16;
    localparam int IRW = 5;

    logic clk = 0, rst = 1;
    logic llc_miss = 0, dc_valid = 0, dc_hit = 0;
    logic [IRW-1:0] instr_inc = '0;
    logic [7:0] rnd = 0, eps = 0;
    logic [23:0] mpki_thr = {8'd12, 8'd8, 8'd4};
    logic [23:0] hit_thr  = {8'd192, 8'd128, 8'd64};
    logic [5:0]  dbg_idx = 0;
    logic [15:0] dbg_q;
    logic [1:0]  pf_code;
    logic [2:0]  pf_onehot;

    always #4 clk = ~clk;

    rl_pf_select #(.WINDOW(WIN), .KILO(KIL), .IRW(IRW)) u_dut (
        .clk(clk), .rst(rst), .llc_miss_i(llc_miss), .dc_valid_i(dc_valid),
        .dc_hit_i(dc_hit), .instr_inc_i(instr_inc), .rand_i(rnd), .eps_i(eps),
        .mpki_thr_i(mpki_thr), .hit_thr_i(hit_thr), .dbg_idx_i(dbg_idx),
        .dbg_q_o(dbg_q), .pf_code_o(pf_code), .pf_onehot_o(pf_onehot)
    );

    int n_chk = 0, n_bad = 0;
    int exp_q[$];
    string req_q[$];
    event mon_ev;

    int qm[48];
    int hr_m = 0, mpki_m = 0, mcnt_m = 0, acc_m = 0;
    int sp_m = 0, ap_m = 0, sel_m = 0;
    bit pv_m = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int bin_m(input int v, input logic [23:0] t);
        int n = 0;
        for (int i = 0; i < 3; i++) if (v >= int'(t[i*8 +: 8])) n++;
        return n;
    endfunction

    function automatic int blend_m(input int old, input int r, input int best);
        int s;
        s = ((old * 26) >> 8) + (((r + ((best * 205) >> 8)) * 230) >> 8);
        return (s > 65535) ? 65535 : s;
    endfunction

    task automatic read_q(input int idx, output int v);
        dbg_idx = 6'(idx);
        #1;
        v = int'(dbg_q);
    endtask

    // scoreboard monitor: pops the expected engine after each decision
    initial begin
        forever begin
            @(mon_ev);
            if (exp_q.size() != 0) begin
                int e;
                string r;
                e = exp_q.pop_front();
                r = req_q.pop_front();
                check(int'(pf_code) == e, r, int'(pf_code), e);
                check(pf_onehot == (3'b001 << e), "R9 onehot", int'(pf_onehot), 1 << e);
            end
        end
    end

    task automatic dc_burst(input int n, input int hits);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            dc_valid = 1;
            dc_hit   = (i < hits);
        end
        @(negedge clk);
        dc_valid = 0;
        dc_hit   = 0;
        hr_m = (hits * 256) / WIN;
        if (hr_m > 255) hr_m = 255;
    endtask

    task automatic retire(input int inc);
        @(negedge clk);
        instr_inc = IRW'(inc);
        @(negedge clk);
        instr_inc = '0;
        acc_m += inc;
        if (acc_m >= KIL) begin
            mpki_m = (mcnt_m > 255) ? 255 : mcnt_m;
            mcnt_m = 0;
            acc_m -= KIL;
        end
    endtask

    // driver: one learner step, model computed and pushed to the scoreboard
    task automatic do_miss(input int r8, input int e8, input int hold, input string req);
        int sc, widx, best, a, v, old_sel;
        @(negedge clk);
        llc_miss = 1;
        rnd = 8'(r8);
        eps = 8'(e8);
        sc = bin_m(mpki_m, mpki_thr) * 4 + bin_m(hr_m, hit_thr);
        widx = sp_m * 3 + ap_m;
        best = qm[sc*3];
        for (int k = 1; k < 3; k++) if (qm[sc*3+k] > best) best = qm[sc*3+k];
        if (pv_m) qm[widx] = blend_m(qm[widx], hr_m, best);
        if (r8 < e8) begin
            a = r8 % 4;
            if (a == 3) a = 0;
        end else begin
            a = 0;
            for (int k = 1; k < 3; k++) if (qm[sc*3+k] > qm[sc*3+a]) a = k;
        end
        old_sel = sel_m;
        sel_m = a; sp_m = sc; ap_m = a; pv_m = 1;
        mcnt_m += hold;
        repeat (hold) @(negedge clk);
        llc_miss = 0;
        repeat (2 - hold) @(negedge clk);
        check(int'(pf_code) == old_sel, "R8 output held during update", int'(pf_code), old_sel);
        read_q(widx, v);
        check(v == qm[widx], "R5 updated entry", v, qm[widx]);
        @(negedge clk);
        exp_q.push_back(a);
        req_q.push_back(req);
        ->mon_ev;
        #1;
    endtask

    initial begin
        int v;
        for (int i = 0; i < 48; i++) qm[i] = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        check(pf_code == 2'd0, "R1 engine after reset", int'(pf_code), 0);
        check(pf_onehot == 3'b001, "R1 onehot after reset", int'(pf_onehot), 1);
        for (int i = 0; i < 48; i += 7) begin
            read_q(i, v);
            check(v == 0, "R1 entry zero", v, 0);
        end
        read_q(50, v);
        check(v == 0, "R9 out-of-range debug index", v, 0);

        // R2: 8 hits of 16 -> 128; R3: retire latches zero misses
        dc_burst(WIN, 8);
        retire(KIL);
        // first miss: no update, greedy tie -> 0 (R5, R6)
        do_miss(0, 0, 1, "R6 first pick");
        read_q(6, v);
        check(v == 0, "R5 first miss leaves table", v, 0);
        // second: update with reward 128 (R2, R4, R5)
        do_miss(0, 0, 1, "R6 greedy");
        read_q(6, v);
        check(v == 115, "R2 reward from 8/16 hits", v, 115);
        // R7 random picks
        do_miss(1, 255, 1, "R7 random code 1");
        do_miss(3, 255, 1, "R7 random code 3 remapped");
        do_miss(1, 255, 1, "R7 random code 1 again");
        // R7 boundary: rnd == eps -> greedy, expected non-zero argmax
        do_miss(5, 5, 1, "R7 equal threshold is greedy");
        check(sel_m == 1, "R6 greedy non-zero engine", sel_m, 1);
        // R2 saturated fraction, R4 new state, R6 tie in fresh row
        dc_burst(WIN, 16);
        do_miss(0, 0, 1, "R6 tie lowest code");
        // R8 busy strobe ignored by learner
        do_miss(2, 255, 2, "R8 strobe during update ignored");
        // R3 miss count latch: 9 misses -> bin 2, state 11
        retire(KIL);
        check(mpki_m == 9, "R3 model miss count", mpki_m, 9);
        do_miss(0, 0, 1, "R4 state from miss rate");
        do_miss(2, 255, 1, "R7 random code 2");
        do_miss(0, 0, 1, "R6 greedy code 2");
        read_q(35, v);
        check(v == qm[35] && v != 0, "R4 entry index 11*3+2", v, qm[35]);
        repeat (4) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #200000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule